// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge Unit

This unit answers the two read requests a virtual CPU makes for a chosen interrupt group. A *peek* asks for the highest-priority pending virtual interrupt. An *acknowledge* takes that interrupt and makes it active. An arbiter outside the unit compares the list registers against the pending virtual LPI. It hands over a winner code, the virtual LPI candidate (ID, priority, group and the group-priority mask for that group) and the result of the preemption test. The unit then returns either the candidate's ID or the spurious ID 1023.

A successful acknowledge has two side effects, both in the same cycle as the response:

- It sends a one-cycle strobe naming the bit to set in the active-priority bank. The bank sits outside the unit and is organised as 32-bit words per group.
- It sends a one-cycle clear-pending pulse to the redistributor, carrying the ID.

After such a pulse the candidate counts as consumed until the redistributor signals a refreshed candidate. This stops the same virtual LPI from being taken twice.

Requests and responses use valid/ready. The unit holds one response:

- A request is taken only when no response is waiting, or when the waiting response is drained in the same cycle.
- A response, once valid, does not change until it is taken.

The strobe and pulse outputs are plain and have no back-pressure.

Top module: `virq_ack_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_valid`, `ap_set_valid` and `clr_valid` are low and `rd_ready` is high.
- R2: `rd_ready` equals `!rsp_valid || rsp_ready`. A request taken at a clock edge shows its response from that edge on. While `rsp_valid` is high and `rsp_ready` is low, `rsp_id` stays unchanged.
- R3: A peek (`rd_ack`=0) returns `vlpi_id` only when all of these hold: `win_code` is 2'b10 (virtual LPI wins), `vlpi_grp` equals `rd_grp`, and the candidate is not consumed. Otherwise it returns 1023. A peek never raises `ap_set_valid` or `clr_valid`.
- R4: The winner codes 2'b00 (nothing pending), 2'b01 (list register wins, answered by another unit) and 2'b11 (reserved) always make this unit return 1023.
- R5: An acknowledge (`rd_ack`=1) returns `vlpi_id` only when the R3 conditions hold and `preempt_ok` is high. Otherwise it returns 1023 and raises neither strobe.
- R6: On a successful acknowledge, `ap_set_valid` pulses with `ap_set_grp`=`vlpi_grp`. The bit number n is `(vlpi_prio & vlpi_gmask) >> (8 - PRE_BITS)`; `ap_set_word` is n/32 and `ap_set_bit` is n%32. With PRE_BITS=7 this gives words 0 to 3.
- R7: On a successful acknowledge, `clr_valid` is high for exactly one cycle, in the same cycle as `ap_set_valid`, with `clr_id` equal to the response ID.
- R8: After a clear-pending pulse, the candidate counts as consumed, and both peek and acknowledge return 1023 for it. This lasts until `vlpi_upd` is seen high in a cycle after the pulse. A `vlpi_upd` at or before the pulse is ignored.
- R9: A candidate with priority 8'hFF means no virtual LPI is pending. It is never returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be taken |
| rd_ack | input | 1 | 1 = acknowledge, 0 = peek |
| rd_grp | input | 1 | Group of the register being read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_id | output | 16 | Returned interrupt ID or 1023 |
| win_code | input | 2 | Arbiter winner code |
| vlpi_id | input | 16 | Candidate virtual LPI ID |
| vlpi_prio | input | 8 | Candidate priority |
| vlpi_grp | input | 1 | Candidate group |
| vlpi_gmask | input | 8 | Group-priority mask for the candidate's group |
| preempt_ok | input | 1 | Candidate passes the preemption test |
| vlpi_upd | input | 1 | Redistributor has refreshed the candidate |
| ap_set_valid | output | 1 | Set-active-priority strobe |
| ap_set_grp | output | 1 | Bank group to set |
| ap_set_word | output | AP_WORD_W | Word index in that bank |
| ap_set_bit | output | 5 | Bit position in that word |
| clr_valid | output | 1 | Clear-pending pulse to the redistributor |
| clr_id | output | 16 | ID to mark not pending |

## Verification
The hardest case to reach from the ports is a second acknowledge of a candidate that is still unchanged after its clear-pending pulse has gone out. The stimulus gets there by holding every candidate input steady and issuing further peeks and acknowledges before pulsing `vlpi_upd`. Both must come back as 1023, and no strobe may appear. A related case is a held response under back-pressure while a new request waits. The bench reaches it by dropping `rsp_ready` across two queued peeks.

// File: rtl/virq_ack_pkg.sv
package virq_ack_pkg;
  localparam int ID_W = 16;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 16'd1023;
  localparam logic [7:0] PRIO_IDLE = 8'hFF;

  typedef enum logic [1:0] {
    WIN_NONE = 2'b00,
    WIN_LIST = 2'b01,
    WIN_VLPI = 2'b10,
    WIN_RSVD = 2'b11
  } win_code_e;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [7:0]      prio;
    logic            grp;
  } vcand_t;
endpackage

// File: rtl/virq_ack_decide.sv
module virq_ack_decide
  import virq_ack_pkg::*;
(
  input  logic [1:0]      win_code,
  input  vcand_t          cand,
  input  logic            req_grp,
  input  logic            req_ack,
  input  logic            preempt_ok,
  input  logic            consumed,
  output logic [ID_W-1:0] resp_id,
  output logic            take
);
  win_code_e win;
  logic      visible;
  logic      answer;

  always_comb begin
    win     = win_code_e'(win_code);
    visible = (win == WIN_VLPI) && (cand.grp == req_grp)
              && (cand.prio != PRIO_IDLE) && !consumed;
    answer  = visible && (!req_ack || preempt_ok);
    take    = visible && req_ack && preempt_ok;
    resp_id = answer ? cand.id : SPURIOUS_ID;
  end
endmodule

// File: rtl/virq_ack_apidx.sv
module virq_ack_apidx #(
  parameter int PRE_BITS = 7,
  localparam int SHIFT   = 8 - PRE_BITS,
  localparam int WORDS   = 1 << (PRE_BITS - 5),
  localparam int WORD_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [7:0]        prio,
  input  logic [7:0]        gmask,
  output logic [WORD_W-1:0] word,
  output logic [4:0]        bitpos
);
  logic [PRE_BITS-1:0] bnum;

  assign bnum   = PRE_BITS'((prio & gmask) >> SHIFT);
  assign bitpos = bnum[4:0];

  generate
    if (PRE_BITS > 5) begin : g_multi_word
      assign word = bnum[PRE_BITS-1:5];
    end else begin : g_single_word
      assign word = '0;
    end
  endgenerate
endmodule

// File: rtl/virq_ack_guard.sv
module virq_ack_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic issued,
  input  logic refresh,
  output logic consumed
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   consumed <= 1'b0;
    else if (grant)               consumed <= 1'b1;
    else if (refresh && !issued)  consumed <= 1'b0;
  end
endmodule

// File: rtl/virq_ack_unit.sv
module virq_ack_unit
  import virq_ack_pkg::*;
#(
  parameter int PRE_BITS   = 7,
  localparam int AP_WORDS  = 1 << (PRE_BITS - 5),
  localparam int AP_WORD_W = (AP_WORDS > 1) ? $clog2(AP_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic                 rd_ack,
  input  logic                 rd_grp,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [15:0]          rsp_id,
  input  logic [1:0]           win_code,
  input  logic [15:0]          vlpi_id,
  input  logic [7:0]           vlpi_prio,
  input  logic                 vlpi_grp,
  input  logic [7:0]           vlpi_gmask,
  input  logic                 preempt_ok,
  input  logic                 vlpi_upd,
  output logic                 ap_set_valid,
  output logic                 ap_set_grp,
  output logic [AP_WORD_W-1:0] ap_set_word,
  output logic [4:0]           ap_set_bit,
  output logic                 clr_valid,
  output logic [15:0]          clr_id
);
  vcand_t                cand;
  logic                  accept;
  logic                  take;
  logic                  consumed;
  logic [ID_W-1:0]       resp_id_d;
  logic [AP_WORD_W-1:0]  word_d;
  logic [4:0]            bit_d;

  assign cand     = '{id: vlpi_id, prio: vlpi_prio, grp: vlpi_grp};
  assign rd_ready = !rsp_valid || rsp_ready;
  assign accept   = rd_valid && rd_ready;

  virq_ack_decide u_decide (
    .win_code   (win_code),
    .cand       (cand),
    .req_grp    (rd_grp),
    .req_ack    (rd_ack),
    .preempt_ok (preempt_ok),
    .consumed   (consumed),
    .resp_id    (resp_id_d),
    .take       (take)
  );

  virq_ack_apidx #(.PRE_BITS(PRE_BITS)) u_apidx (
    .prio   (vlpi_prio),
    .gmask  (vlpi_gmask),
    .word   (word_d),
    .bitpos (bit_d)
  );

  virq_ack_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (accept && take),
    .issued   (clr_valid),
    .refresh  (vlpi_upd),
    .consumed (consumed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_id       <= SPURIOUS_ID;
      ap_set_valid <= 1'b0;
      ap_set_grp   <= 1'b0;
      ap_set_word  <= '0;
      ap_set_bit   <= '0;
      clr_valid    <= 1'b0;
      clr_id       <= '0;
    end else begin
      ap_set_valid <= 1'b0;
      clr_valid    <= 1'b0;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_id    <= resp_id_d;
        if (take) begin
          ap_set_valid <= 1'b1;
          ap_set_grp   <= vlpi_grp;
          ap_set_word  <= word_d;
          ap_set_bit   <= bit_d;
          clr_valid    <= 1'b1;
          clr_id       <= vlpi_id;
        end
      end
    end
  end
endmodule

// File: rtl/virq_ack_chk.sv
module virq_ack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic        rd_ack,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_id,
  input logic [7:0]  vlpi_prio,
  input logic        vlpi_upd,
  input logic        ap_set_valid,
  input logic        clr_valid,
  input logic [15:0] clr_id
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (clr_valid) pend_q <= 1'b1;
    else if (vlpi_upd)  pend_q <= 1'b0;
  end

  AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_id)); // R2
  AST_READY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !rd_ready); // R2
  AST_SET_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ap_set_valid |-> $past(rd_valid && rd_ready && rd_ack)); // R5
  AST_SET_NOT_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    ap_set_valid |-> rsp_id != 16'd1023); // R5
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> !clr_valid); // R7
  AST_CLR_WITH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> ap_set_valid && rsp_valid && rsp_id == clr_id); // R7
  AST_NO_REACK: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> !pend_q); // R8
  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    ap_set_valid |-> $past(vlpi_prio) != 8'hFF); // R9
endmodule

bind virq_ack_unit virq_ack_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_valid     (rd_valid),
  .rd_ready     (rd_ready),
  .rd_ack       (rd_ack),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_id       (rsp_id),
  .vlpi_prio    (vlpi_prio),
  .vlpi_upd     (vlpi_upd),
  .ap_set_valid (ap_set_valid),
  .clr_valid    (clr_valid),
  .clr_id       (clr_id)
);

// File: tb/virq_ack_unit_tb.sv
module virq_ack_unit_tb;
  localparam int PB = 7;

  typedef struct packed {
    logic [15:0] id;
    logic        set;
    logic        grp;
    logic [1:0]  word;
    logic [4:0]  bitp;
    logic [7:0]  tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_valid = 1'b0, rd_ack = 1'b0, rd_grp = 1'b0, rsp_ready = 1'b1;
  logic [1:0]  win_code = 2'b00;
  logic [15:0] vlpi_id = '0;
  logic [7:0]  vlpi_prio = 8'hFF, vlpi_gmask = 8'hFF;
  logic        vlpi_grp = 1'b0, preempt_ok = 1'b0, vlpi_upd = 1'b0;
  logic        rd_ready, rsp_valid, ap_set_valid, ap_set_grp, clr_valid;
  logic [15:0] rsp_id, clr_id;
  logic [1:0]  ap_set_word;
  logic [4:0]  ap_set_bit;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit outst = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  virq_ack_unit #(.PRE_BITS(PB)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_ack(rd_ack), .rd_grp(rd_grp), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_id(rsp_id), .win_code(win_code),
    .vlpi_id(vlpi_id), .vlpi_prio(vlpi_prio), .vlpi_grp(vlpi_grp),
    .vlpi_gmask(vlpi_gmask), .preempt_ok(preempt_ok), .vlpi_upd(vlpi_upd),
    .ap_set_valid(ap_set_valid), .ap_set_grp(ap_set_grp),
    .ap_set_word(ap_set_word), .ap_set_bit(ap_set_bit),
    .clr_valid(clr_valid), .clr_id(clr_id)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: compute expectation from the requirements, push, then hand over
  task automatic send(input bit ack, input bit grp, input string req);
    exp_t e;
    bit acc;
    bit vis;
    int n;
    @(posedge clk); #2;
    rd_valid = 1'b1; rd_ack = ack; rd_grp = grp;
    do begin
      @(negedge clk);
      acc = rd_ready;
      if (acc) begin
        vis = (win_code == 2'b10) && (vlpi_grp == grp) && (vlpi_prio != 8'hFF) && !outst;
        e = '0;
        e.tag = req.getc(1);
        e.id = 16'd1023;
        if (vis && (!ack || preempt_ok)) e.id = vlpi_id;
        if (vis && ack && preempt_ok) begin
          n = int'(vlpi_prio & vlpi_gmask) >> (8 - PB);
          e.set = 1'b1; e.grp = vlpi_grp;
          e.word = 2'(n / 32); e.bitp = 5'(n % 32);
          outst = 1'b1;
        end
        q.push_back(e);
      end
      @(posedge clk);
    end while (!acc);
    #2 rd_valid = 1'b0;
  endtask

  task automatic set_cand(input logic [1:0] w, input logic [15:0] id, input logic [7:0] pr,
                          input bit g, input logic [7:0] m, input bit po, input bit upd);
    @(posedge clk); #2;
    win_code = w; vlpi_id = id; vlpi_prio = pr; vlpi_grp = g; vlpi_gmask = m;
    preempt_ok = po; vlpi_upd = upd;
    @(posedge clk); #2;
    vlpi_upd = 1'b0;
    if (upd) outst = 1'b0;
  endtask

  // monitor: capture strobes, pop and compare on each response handshake
  bit seen_set = 0, seen_clr = 0, s_grp = 0, prev_stall = 0;
  logic [1:0] s_word; logic [4:0] s_bit; logic [15:0] c_id, prev_id;
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      string rq;
      if (ap_set_valid) begin seen_set = 1; s_grp = ap_set_grp; s_word = ap_set_word; s_bit = ap_set_bit; end
      if (clr_valid) begin seen_clr = 1; c_id = clr_id; end
      if (prev_stall) check(rsp_valid && rsp_id == prev_id, "R2 hold", rsp_id, prev_id);
      prev_stall = rsp_valid && !rsp_ready;
      prev_id = rsp_id;
      if (rsp_valid && rsp_ready) begin
        if (q.size() == 0) check(0, "R2 extra response", rsp_id, 0);
        else begin
          e = q.pop_front();
          rq = $sformatf("R%0s", string'(e.tag));
          check(rsp_id == e.id, rq, rsp_id, e.id);
          if (e.set) begin
            check(seen_set && s_grp == e.grp && s_word == e.word && s_bit == e.bitp,
                  "R6 set", {seen_set, s_grp, s_word, s_bit}, {1'b1, e.grp, e.word, e.bitp});
            check(seen_clr && c_id == e.id, "R7 clear", c_id, e.id);
          end else begin
            check(!seen_set && !seen_clr, rq, {seen_set, seen_clr}, 0);
          end
        end
        seen_set = 0; seen_clr = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(!rsp_valid && !ap_set_valid && !clr_valid && rd_ready, "R1 in reset",
          {rsp_valid, ap_set_valid, clr_valid, rd_ready}, 1);
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    check(!rsp_valid && !ap_set_valid && !clr_valid && rd_ready, "R1 after reset",
          {rsp_valid, ap_set_valid, clr_valid, rd_ready}, 1);
    // R4: non-vLPI winner codes
    set_cand(2'b00, 16'h2345, 8'h40, 1, 8'hF8, 1, 0); send(0, 1, "R4");
    set_cand(2'b01, 16'h2345, 8'h40, 1, 8'hF8, 1, 0); send(1, 1, "R4");
    set_cand(2'b11, 16'h2345, 8'h40, 1, 8'hF8, 1, 0); send(0, 1, "R4");
    // R3 peek, group match and mismatch
    set_cand(2'b10, 16'h2345, 8'h40, 1, 8'hF8, 0, 0);
    send(0, 1, "R3"); send(0, 0, "R3");
    // R5 ack: wrong group, preemption fails
    send(1, 0, "R5"); send(1, 1, "R5");
    // R6/R7 ack: n = 0x40>>1 = 32 -> word 1 bit 0
    set_cand(2'b10, 16'h2345, 8'h40, 1, 8'hF8, 1, 0);
    send(1, 1, "R6");
    // R8: candidate unchanged, consumed
    send(0, 1, "R8"); send(1, 1, "R8");
    // refresh: n = 0xE6>>1 = 115 -> word 3 bit 19, group 0
    set_cand(2'b10, 16'h0077, 8'hE7, 0, 8'hFE, 1, 1);
    send(1, 0, "R6");
    set_cand(2'b10, 16'h0088, 8'hFF, 0, 8'hFF, 1, 1);
    send(0, 0, "R9"); send(1, 0, "R9");
    set_cand(2'b10, 16'hFFFE, 8'h00, 1, 8'h80, 1, 1);
    send(1, 1, "R7");
    // R2 back-pressure
    set_cand(2'b10, 16'h0100, 8'h10, 1, 8'hF0, 1, 1);
    @(posedge clk); #2 rsp_ready = 1'b0;
    fork
      begin send(0, 1, "R2"); send(0, 1, "R2"); end
      begin
        repeat (5) @(posedge clk);
        #4;
        check(rsp_valid && !rd_ready, "R2 stall", {rsp_valid, rd_ready}, 2);
        rsp_ready = 1'b1;
      end
    join
    repeat (4) @(posedge clk);
    check(q.size() == 0, "R2 drained", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule